// File: doc/BRIEF.md
# Six-Output Shared-Period PWM Generator

This block drives six pulse-width-modulated logic levels from one common time base. A prescaler divides the input clock. A period counter steps on each prescaler tick and restarts after it reaches the period value. Every output compares the period counter against its own compare value. An output can run in single-edge form, where it rises at the start of the period and falls at its compare point. The even-numbered outputs can also run in double-edge form, where two compare values place both the rising and the falling edge.

Software loads all settings through a plain write port: seven compare registers, a prescale register and a pair-enable register. Every written value first lands in a holding copy. All holding copies move into the working set together at the start of the next period. A new setting therefore never cuts a period short and never makes an extra edge. A double-edge output borrows the compare register of its odd-numbered neighbour, so each double-edge output costs one extra register.

Top module: `multi_edge_pwm`

## Requirements
- R1: While `rstN` is low, and after its release until anything is written, all six outputs are low. All compare, prescale and pair-enable values start at zero.
- R2: Write address 7 sets the prescale value P. The period counter advances once every P+1 clock cycles, so it steps on every cycle when P is 0 and on every second cycle when P is 1.
- R3: Write address 0 sets the period value N. The period counter counts 0, 1, …, N and then returns to 0 on the next tick, so one period lasts N+1 ticks.
- R4: Output bit j (`pwmOut[j]`) is channel j+1 and uses compare register j+1 (write address j+1). In single-edge form with compare value M, where 0 < M < N, the channel is high while the period count is below M and low from M up to N.
- R5: In single-edge form, M = 0 holds the channel low for the whole period, and any M ≥ N (with M nonzero) holds it high without a break.
- R6: Write address 8 sets the pair-enable bits. Bit k (0 to 2) puts channel 2k+2 into double-edge form. In that form the channel is high while S ≤ count < C, where S is compare register 2k+1 (the set point) and C is compare register 2k+2 (the clear point).
- R7: In double-edge form, S ≥ C keeps the channel low for the whole period, and S = 0 with C > N keeps it high for the whole period.
- R8: When its pair is in double-edge form, odd channel 2k+1 still gives its single-edge waveform from compare register 2k+1.
- R9: Writes to addresses 0 to 8 change no output and no counter step until the period ends. All of them take effect together at the tick on which the counter returns to 0.
- R10: Writes to addresses 9 to 15 are ignored and change no output.
- R11: Each pair follows its own enable bit, so single-edge and double-edge channels can run side by side under the same period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that is divided down to the counting ticks |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the settings port |
| wrAddr | input | 4 | Setting address: 0–6 compare, 7 prescale, 8 pair enables |
| wrData | input | 32 | Value to write |
| pwmOut | output | 6 | Channel levels, bit j is channel j+1 |

## Verification
The assertions check on every cycle how the time base moves. The prescale count never goes past its limit. The period count stays within the period, holds between ticks, steps by one and returns to zero after the last tick. The working settings change only on a period wrap, and no output moves unless the counter has stepped. The waveform shapes cannot be checked this way: edge placement, the zero and full-duty corners, double-edge windows, a single-edge output running beside its double-edge partner, and ignored addresses. Only the bench scenarios can show these. There, a requirement-level model of the outputs is compared with the design on every cycle, and high-time counts over whole periods are compared with values worked out by hand.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  // Strobes handed from the timing control to the datapath each cycle.
  typedef struct packed {
    logic countEn;  // prescaler tick: period counter may step
    logic wrapEn;   // tick on the last count: restart and load settings
  } pwmStrobe_t;

endpackage

// File: rtl/pwm_ctrl.sv
module pwm_ctrl #(
  parameter int CNT_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [CNT_W-1:0]    prescaleLimit,
  input  logic                countAtEnd,
  output logic [CNT_W-1:0]    prescaleCount,
  output pwm_pkg::pwmStrobe_t strobe
);

  logic tickNow;

  // A greater-or-equal compare keeps the divider safe when the limit shrinks.
  assign tickNow = (prescaleCount >= prescaleLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prescaleCount <= '0;
    end else if (tickNow) begin
      prescaleCount <= '0;
    end else begin
      prescaleCount <= prescaleCount + CNT_W'(1);
    end
  end

  always_comb begin
    strobe.countEn = tickNow;
    strobe.wrapEn  = tickNow && countAtEnd;
  end

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int CNT_W = 32
) (
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] periodLimit,
  input  logic [CNT_W-1:0] ownMatch,
  input  logic [CNT_W-1:0] setMatch,
  input  logic             pairOn,
  output logic             level
);

  logic singleLvl;
  logic pairLvl;

  always_comb begin
    // single-edge: zero means never on, at or past the period means always on
    if (ownMatch == '0) begin
      singleLvl = 1'b0;
    end else if (ownMatch >= periodLimit) begin
      singleLvl = 1'b1;
    end else begin
      singleLvl = (count < ownMatch);
    end
    // double-edge window: on at the set point, off at the clear point
    pairLvl = (count >= setMatch) && (count < ownMatch);
    level   = pairOn ? pairLvl : singleLvl;
  end

endmodule

// File: rtl/pwm_datapath.sv
module pwm_datapath #(
  parameter int NUM_CH = 6,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  pwm_pkg::pwmStrobe_t strobe,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [CNT_W-1:0]    wrData,
  output logic [CNT_W-1:0]    periodCount,
  output logic [CNT_W-1:0]    periodLimit,
  output logic [CNT_W-1:0]    prescaleLimit,
  output logic                countAtEnd,
  output logic [NUM_CH-1:0]   pwmOut
);

  localparam int NUM_MATCH = NUM_CH + 1;
  localparam int NUM_PAIR  = NUM_CH / 2;
  localparam int PRE_ADDR  = NUM_MATCH;
  localparam int MODE_ADDR = NUM_MATCH + 1;

  logic [CNT_W-1:0]    shadowMatch [NUM_MATCH];
  logic [CNT_W-1:0]    activeMatch [NUM_MATCH];
  logic [CNT_W-1:0]    shadowPre;
  logic [CNT_W-1:0]    activePre;
  logic [NUM_PAIR-1:0] shadowMode;
  logic [NUM_PAIR-1:0] activeMode;
  logic [NUM_CH:1]     pairOn;

  // Holding copies written by the settings port.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_MATCH; i++) shadowMatch[i] <= '0;
      shadowPre  <= '0;
      shadowMode <= '0;
    end else if (wrEn) begin
      for (int i = 0; i < NUM_MATCH; i++) begin
        if (wrAddr == ADDR_W'(i)) shadowMatch[i] <= wrData;
      end
      if (wrAddr == ADDR_W'(PRE_ADDR))  shadowPre  <= wrData;
      if (wrAddr == ADDR_W'(MODE_ADDR)) shadowMode <= wrData[NUM_PAIR-1:0];
    end
  end

  // Working set, swapped in as one at the period wrap.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_MATCH; i++) activeMatch[i] <= '0;
      activePre  <= '0;
      activeMode <= '0;
    end else if (strobe.wrapEn) begin
      for (int i = 0; i < NUM_MATCH; i++) activeMatch[i] <= shadowMatch[i];
      activePre  <= shadowPre;
      activeMode <= shadowMode;
    end
  end

  // Shared period counter.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodCount <= '0;
    end else if (strobe.countEn) begin
      periodCount <= strobe.wrapEn ? '0 : periodCount + CNT_W'(1);
    end
  end

  assign periodLimit   = activeMatch[0];
  assign prescaleLimit = activePre;
  assign countAtEnd    = (periodCount == activeMatch[0]);

  // One compare slice per channel; only even channels may pair up.
  for (genvar ch = 1; ch <= NUM_CH; ch++) begin : g_chan
    if (ch % 2 == 0) begin : g_pair
      assign pairOn[ch] = activeMode[ch/2 - 1];
    end else begin : g_solo
      assign pairOn[ch] = 1'b0;
    end

    pwm_chan #(.CNT_W(CNT_W)) u_chan (
      .count       (periodCount),
      .periodLimit (activeMatch[0]),
      .ownMatch    (activeMatch[ch]),
      .setMatch    (activeMatch[ch-1]),
      .pairOn      (pairOn[ch]),
      .level       (pwmOut[ch-1])
    );
  end

endmodule

// File: rtl/multi_edge_pwm.sv
module multi_edge_pwm #(
  parameter  int NUM_CH = 6,
  parameter  int CNT_W  = 32,
  localparam int ADDR_W = $clog2(NUM_CH + 3)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  output logic [NUM_CH-1:0] pwmOut
);

  pwm_pkg::pwmStrobe_t strobe;
  logic [CNT_W-1:0]    prescaleCount;
  logic [CNT_W-1:0]    prescaleLimit;
  logic [CNT_W-1:0]    periodCount;
  logic [CNT_W-1:0]    periodLimit;
  logic                countAtEnd;

  pwm_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .prescaleLimit (prescaleLimit),
    .countAtEnd    (countAtEnd),
    .prescaleCount (prescaleCount),
    .strobe        (strobe)
  );

  pwm_datapath #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_data (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .wrEn          (wrEn),
    .wrAddr        (wrAddr),
    .wrData        (wrData),
    .periodCount   (periodCount),
    .periodLimit   (periodLimit),
    .prescaleLimit (prescaleLimit),
    .countAtEnd    (countAtEnd),
    .pwmOut        (pwmOut)
  );

endmodule

// File: rtl/pwm_checker.sv
module pwm_checker #(
  parameter int NUM_CH = 6,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              countEn,
  input logic              wrapEn,
  input logic [CNT_W-1:0]  periodCount,
  input logic [CNT_W-1:0]  periodLimit,
  input logic [CNT_W-1:0]  prescaleCount,
  input logic [CNT_W-1:0]  prescaleLimit,
  input logic [NUM_CH-1:0] pwmOut
);

  // R2: divider never runs past its limit
  a_r2_prescale_bound: assert property (@(posedge clk) disable iff (!rstN)
    prescaleCount <= prescaleLimit);

  // R2: no tick, no step
  a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (!rstN)
    !countEn |=> $stable(periodCount));

  // R3: the counter stays inside the period
  a_r3_count_in_range: assert property (@(posedge clk) disable iff (!rstN)
    periodCount <= periodLimit);

  // R3: the last tick of a period restarts the count
  a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (!rstN)
    wrapEn |=> periodCount == '0);

  // R3: any other tick steps by one
  a_r3_step_by_one: assert property (@(posedge clk) disable iff (!rstN)
    (countEn && !wrapEn) |=> periodCount == $past(periodCount) + CNT_W'(1));

  // R9: working settings change only on a wrap
  a_r9_settings_hold: assert property (@(posedge clk) disable iff (!rstN)
    !wrapEn |=> ($stable(periodLimit) && $stable(prescaleLimit)));

  // R9: outputs move only after a counter step
  a_r9_out_hold: assert property (@(posedge clk) disable iff (!rstN)
    !countEn |=> $stable(pwmOut));

endmodule

bind multi_edge_pwm pwm_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) i_chk (
  .clk           (clk),
  .rstN          (rstN),
  .countEn       (strobe.countEn),
  .wrapEn        (strobe.wrapEn),
  .periodCount   (periodCount),
  .periodLimit   (periodLimit),
  .prescaleCount (prescaleCount),
  .prescaleLimit (prescaleLimit),
  .pwmOut        (pwmOut)
);

// File: tb/test_multi_edge_pwm.sv
`timescale 1ns/1ps
module test_multi_edge_pwm;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [5:0]  pwmOut;

  int    total = 0;
  int    bad   = 0;
  bit    finished = 0;
  string curReq = "R1";

  always #2 clk = ~clk;  // 250 MHz

  multi_edge_pwm i_multi_edge_pwm (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .pwmOut(pwmOut)
  );

  // ---- requirement-level model: index 0..6 compare, 7 prescale, 8 pair bits
  logic [31:0] mSh  [0:8];
  logic [31:0] mAct [0:8];
  logic [31:0] mPc, mTc;
  logic        mTick, mWrap;
  logic [5:0]  expQ [$];

  function automatic logic [5:0] modelOut();
    logic [5:0] v;
    for (int ch = 1; ch <= 6; ch++) begin
      if (mAct[ch] == 0)            v[ch-1] = 1'b0;      // R5 zero
      else if (mAct[ch] >= mAct[0]) v[ch-1] = 1'b1;      // R5 full
      else                          v[ch-1] = (mTc < mAct[ch]); // R4
      if (ch % 2 == 0 && mAct[8][ch/2-1])                // R6 window
        v[ch-1] = (mTc >= mAct[ch-1]) && (mTc < mAct[ch]);
    end
    return v;
  endfunction

  // driver side of the scoreboard: push the expected level set each edge
  always @(posedge clk) begin
    if (!rstN) begin
      mPc = 0; mTc = 0;
      for (int i = 0; i < 9; i++) begin mSh[i] = 0; mAct[i] = 0; end
    end else begin
      mTick = (mPc >= mAct[7]);
      mWrap = mTick && (mTc == mAct[0]);
      if (mWrap) for (int i = 0; i < 9; i++) mAct[i] = mSh[i];  // R9
      if (wrEn && wrAddr <= 4'd8) mSh[wrAddr] = wrData;          // R10 above 8
      mPc = mTick ? 0 : mPc + 1;
      if (mWrap) mTc = 0; else if (mTick) mTc = mTc + 1;
    end
    expQ.push_back(modelOut());
  end

  // monitor side: pop and compare away from the active edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      logic [5:0] e;
      e = expQ.pop_front();
      total++;
      if (pwmOut !== e) begin
        bad++;
        $display("FAIL %s cycle compare: pwmOut=%b expected=%b at %0t",
                 curReq, pwmOut, e, $time);
      end
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // high time over a window spanning whole periods is independent of phase
  task automatic duty(int ch, int win, int expHigh, string req);
    int hi = 0;
    for (int i = 0; i < win; i++) begin
      @(negedge clk);
      if (pwmOut[ch-1]) hi++;
    end
    check(hi == expHigh, req, hi, expHigh);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    curReq = "R1";
    idle(4);
    check(pwmOut == 6'b0, "R1 reset outputs", pwmOut, 0);
    rstN = 1'b1;
    duty(1, 20, 0, "R1 idle after release");
    check(pwmOut == 6'b0, "R1 all low after release", pwmOut, 0);

    // R3 R4 R5: single-edge, period 10 ticks, prescale 0
    curReq = "R3 R4 R5";
    put(4'd1, 3); put(4'd2, 0); put(4'd3, 10);
    put(4'd4, 9); put(4'd5, 5); put(4'd6, 1);
    put(4'd0, 9);
    idle(25);
    duty(1, 30, 9,  "R4 ch1 match 3");
    duty(2, 30, 0,  "R5 ch2 zero low");
    duty(3, 30, 30, "R5 ch3 above period high");
    duty(4, 30, 30, "R5 ch4 equal period high");
    duty(5, 30, 15, "R4 ch5 match 5");
    duty(6, 30, 3,  "R3 ch6 match 1");

    // R2: prescale 2 stretches every tick to three clocks
    curReq = "R2";
    put(4'd7, 2);
    idle(40);
    duty(1, 60, 18, "R2 ch1 prescale 2");
    duty(5, 60, 30, "R2 ch5 prescale 2");
    put(4'd7, 1);
    idle(40);
    duty(6, 40, 4, "R2 ch6 prescale 1");

    // R6 R8 R9 R11: pairs 1 and 3 double-edge, pair 2 single
    curReq = "R6 R8 R9 R11";
    put(4'd7, 0);
    put(4'd1, 2); put(4'd2, 7); put(4'd5, 4); put(4'd6, 9);
    put(4'd8, 32'b101);
    idle(40);
    duty(2, 30, 15, "R6 ch2 window 2..7");
    duty(6, 30, 15, "R6 ch6 window 4..9");
    duty(1, 30, 6,  "R8 ch1 single beside pair");
    duty(5, 30, 12, "R8 ch5 single beside pair");
    duty(4, 30, 30, "R11 ch4 stays single");

    // R7: window corners
    curReq = "R7";
    put(4'd1, 7); put(4'd2, 3); put(4'd5, 0); put(4'd6, 12);
    idle(30);
    duty(2, 30, 0,  "R7 set above clear low");
    duty(6, 30, 30, "R7 full window high");
    duty(5, 30, 0,  "R5 ch5 zero low");
    duty(1, 30, 21, "R4 ch1 match 7");

    // R10: addresses 9..15 change nothing
    curReq = "R10";
    for (int a = 9; a <= 15; a++) put(4'(a), 1);
    idle(30);
    duty(1, 30, 21, "R10 ch1 untouched");
    duty(2, 30, 0,  "R10 ch2 untouched");
    duty(3, 30, 30, "R10 ch3 untouched");

    // R1: second reset clears every setting
    curReq = "R1";
    @(negedge clk); rstN = 1'b0;
    idle(3);
    check(pwmOut == 6'b0, "R1 reset mid-run", pwmOut, 0);
    rstN = 1'b1;
    idle(5);
    duty(3, 20, 0, "R1 settings cleared");

    idle(4);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule